// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of a parallel analogue-to-digital converter. A bank of comparators, one per reference tap, presents a thermometer-coded vector. Bit i is 1 when the sampled input lies above tap i+1. The block turns that vector into an unsigned binary code with a priority encoder. The encoder has one more input position than there are comparators, and that extra, lowest-priority position is permanently low. An empty vector therefore encodes to zero.

A single-cycle sample strobe marks each sampling interval. On the clock edge where the strobe is high, the encoded value is captured into an output register. A valid flag then stays high for the following cycle. The code width is a parameter, and the comparator count follows from it as 2^W − 1. A second parameter picks the encoder structure. Both structures give the same result.

Top module: `flash_therm_encoder`

## Requirements
- R1: After an active-low reset, `code_o` is 0 and `code_valid_o` is 0, and both stay so until the first capture.
- R2: A captured all-zero comparator vector gives code 0, because the lowest encoder position is tied low.
- R3: For a clean thermometer vector the captured code equals the number of ones, counting bit 0 as the lowest tap. With 7 taps, `0001111` gives 4 and `1111111` gives 7.
- R4: When the vector has bubbles (a 1 above a 0), the code is index+1 of the highest set bit, and lower bits have no effect. For example, `0000101` gives 3 and `1000000` gives 7.
- R5: `code_o` changes only on a rising edge with `sample_en` high, and then takes the encoding of `therm_i` present at that edge. On every other edge it holds, whatever `therm_i` does.
- R6: `code_valid_o` is high for exactly the cycle after each capturing edge and low after every edge without `sample_en`.
- R7: Strobes on consecutive cycles capture each sample in turn, with `code_valid_o` high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Per-sample capture strobe |
| therm_i | input | 2^OUT_W − 1 | Comparator outputs, bit 0 = lowest tap |
| code_o | output | OUT_W | Registered binary code |
| code_valid_o | output | 1 | One-cycle flag after each capture |

## Verification
Two things can happen in the same cycle: a capture, and the valid flag announcing the previous capture. The bench provokes this with strobes on back-to-back cycles, changing the comparator vector between them. It judges the result by requiring each cycle's code to match its own sample while the flag stays high. It also changes the vector while the strobe is low and confirms that the output holds.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

   typedef enum logic [0:0] {
      ENC_SCAN   = 1'b0,
      ENC_ONEHOT = 1'b1
   } enc_arch_e;

   function automatic int unsigned tap_count(input int unsigned code_w);
      return (32'd1 << code_w) - 32'd1;
   endfunction

endpackage

// File: rtl/flash_prio_enc.sv
module flash_prio_enc
   import flash_enc_pkg::*;
#(
   parameter int unsigned OUT_W    = 3,
   parameter enc_arch_e   ENC_ARCH = ENC_SCAN,
   localparam int unsigned TAPS    = tap_count(OUT_W)
) (
   input  logic [TAPS-1:0]  therm,
   output logic [OUT_W-1:0] code
);

   generate
      if (ENC_ARCH == ENC_SCAN) begin : g_scan
         // ascending scan: the last set bit seen is the highest one
         always_comb begin
            code = '0;
            for (int i = 0; i < int'(TAPS); i++) begin
               if (therm[i]) code = OUT_W'(i + 1);
            end
         end
      end else begin : g_onehot
         // isolate the topmost set bit, then OR its index into the code
         always_comb begin
            logic seen;
            seen = 1'b0;
            code = '0;
            for (int i = int'(TAPS) - 1; i >= 0; i--) begin
               if (therm[i] && !seen) code = code | OUT_W'(i + 1);
               seen = seen | therm[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/flash_code_reg.sv
module flash_code_reg #(
   parameter int unsigned OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [OUT_W-1:0] code_d,
   output logic [OUT_W-1:0] code_q,
   output logic             valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= sample_en;
         if (sample_en) code_q <= code_d;
      end
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(code_q));

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> (code_q == $past(code_d)));

   assert_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> valid_q);

   assert_novalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> !valid_q);

endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
   import flash_enc_pkg::*;
#(
   parameter int unsigned OUT_W    = 3,
   parameter enc_arch_e   ENC_ARCH = ENC_SCAN,
   localparam int unsigned TAPS    = tap_count(OUT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [TAPS-1:0]  therm_i,
   output logic [OUT_W-1:0] code_o,
   output logic             code_valid_o
);

   generate
      if (OUT_W < 2 || OUT_W > 10) begin : g_bad_width
         $error("flash_therm_encoder: OUT_W must lie in 2..10");
      end
   endgenerate

   logic [OUT_W-1:0] enc_code;

   flash_prio_enc #(
      .OUT_W    (OUT_W),
      .ENC_ARCH (ENC_ARCH)
   ) u_enc (
      .therm (therm_i),
      .code  (enc_code)
   );

   flash_code_reg #(
      .OUT_W (OUT_W)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .code_d    (enc_code),
      .code_q    (code_o),
      .valid_q   (code_valid_o)
   );

   assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_i == '0) |-> (enc_code == '0));

   assert_topbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_code != '0) |-> therm_i[enc_code - OUT_W'(1)]);

   assert_nothing_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_i >> enc_code) == '0);

   assert_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (code_o == '0 && !code_valid_o));

endmodule

// File: tb/flash_therm_encoder_tb.sv
module flash_therm_encoder_tb;

   localparam int unsigned W    = 3;
   localparam int unsigned TAPS = (1 << W) - 1;
   localparam int          NVEC = 10;

   // {thermometer vector, expected code}
   localparam logic [TAPS+W-1:0] VEC [NVEC] = '{
      {7'b0000000, 3'd0},   // R2
      {7'b0000001, 3'd1},   // R3
      {7'b0000011, 3'd2},   // R3
      {7'b0001111, 3'd4},   // R3
      {7'b0111111, 3'd6},   // R3
      {7'b1111111, 3'd7},   // R3
      {7'b0000101, 3'd3},   // R4
      {7'b1000000, 3'd7},   // R4
      {7'b0010110, 3'd5},   // R4
      {7'b0101010, 3'd6}    // R4
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sample_en = 1'b0;
   logic [TAPS-1:0] therm_i = '0;
   logic [W-1:0]    code_o;
   logic            code_valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_therm_encoder #(.OUT_W(W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_en    (sample_en),
      .therm_i      (therm_i),
      .code_o       (code_o),
      .code_valid_o (code_valid_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 code", int'(code_o), 0);
      check("R1 valid", int'(code_valid_o), 0);
      rst_n = 1'b1;
      therm_i = 7'b1111111;
      repeat (2) @(negedge clk);
      check("R1 code held", int'(code_o), 0);
      check("R1 valid low", int'(code_valid_o), 0);

      // table walk: capture, then an idle cycle with a changed vector
      for (int k = 0; k < NVEC; k++) begin
         therm_i   = VEC[k][TAPS+W-1:W];
         sample_en = 1'b1;
         @(negedge clk);
         check("R3/R4 code", int'(code_o), int'(VEC[k][W-1:0]));
         check("R6 valid", int'(code_valid_o), 1);
         sample_en = 1'b0;
         therm_i   = ~VEC[k][TAPS+W-1:W];
         @(negedge clk);
         check("R5 hold", int'(code_o), int'(VEC[k][W-1:0]));
         check("R6 valid drop", int'(code_valid_o), 0);
      end

      // R7: back-to-back captures with changing vector
      therm_i = 7'b0000111; sample_en = 1'b1;
      @(negedge clk);
      check("R7 first", int'(code_o), 3);
      check("R7 valid first", int'(code_valid_o), 1);
      therm_i = 7'b0011111;
      @(negedge clk);
      check("R7 second", int'(code_o), 5);
      check("R7 valid second", int'(code_valid_o), 1);
      therm_i = 7'b0000000;
      @(negedge clk);
      check("R7 third R2", int'(code_o), 0);
      check("R7 valid third", int'(code_valid_o), 1);
      sample_en = 1'b0; therm_i = 7'b1111111;
      repeat (3) @(negedge clk);
      check("R5 long hold", int'(code_o), 0);
      check("R6 idle", int'(code_valid_o), 0);

      // R1: reset after activity clears state
      therm_i = 7'b0111111; sample_en = 1'b1;
      @(negedge clk);
      check("R3 pre-reset", int'(code_o), 6);
      sample_en = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      check("R1 reclear code", int'(code_o), 0);
      check("R1 reclear valid", int'(code_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", int'(code_o), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule